// File: doc/BRIEF.md
# Line Card Switch State Controller

This block decides, once per clock, how the four solid-state switches of an analog telephone line card are set. Two break switches join the subscriber line to the line interface circuit for conversation. A ringing-return switch and a ringing switch join the line to a ringing generator instead. The controller takes a ringing command, a command-hold enable, an active-low shutdown request, an over-temperature flag, a strobe marking each zero crossing of the ringing current and a signed battery-voltage sample in whole volts. It drives the switch enables, a state code and an active-low thermal status flag.

The ringing switch can only be released at a current zero crossing, so the way ringing ends sets the order of the switch changes. Dropping the command closes the break switches while the ringing switch still waits for its zero crossing (make-before-break). Raising shutdown opens everything except the ringing switch, which opens at the zero crossing (break-before-make). Shutdown, over-temperature and a battery fault all bypass the command hold. The battery monitor trips at one threshold and recovers at a lower one.

Top module: `linecard_switch_ctrl`

## Requirements
- R1: Three settled states exist: talk (break switches on, ringing-return and ringing off), ringing (ringing-return and ringing on, break switches off) and all-off (every switch off). Break switches and the ringing-return switch are never on together.
- R2: With no forcing condition and the hold disabled, a ringing command of 1 selects ringing and 0 selects talk.
- R3: While `hold_en` is 0 the command passes straight through. While `hold_en` is 1 the block uses the command value it last saw while `hold_en` was 0 (0 after reset) and ignores command changes.
- R4: A low `shdn_req_n` forces all-off whatever the command and hold inputs are, and is not held by the command hold.
- R5: Once on, the ringing switch turns off only in a cycle where `zc_strobe` is 1; the ringing-return switch turns off in the same cycle as the decision to leave ringing.
- R6: Ringing command falling to 0 during ringing: break switches on and ringing-return off at once, ringing switch on until the next zero-crossing strobe, then talk.
- R7: Shutdown asserted during ringing: break switches and ringing-return off at once, ringing switch on until the next zero crossing, then all-off; releasing shutdown with command 0 gives talk.
- R8: A battery sample above -10 forces all-off; the fault clears only on a sample below -15. Samples from -15 to -10 inclusive keep the previous fault condition.
- R9: A set `overtemp` forces all-off and drives `shdn_stat_n` low; `shdn_stat_n` is high otherwise.
- R10: Reset gives all-off with the battery fault set and `shdn_stat_n` high; talk or ringing can follow only after a sample below -15.
- R11: `state_code` is 0 for all-off, 1 for talk, 2 for ringing and 3 while the ringing switch is on waiting for a zero crossing with the ringing-return switch off.
- R12: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_cmd | input | 1 | 1 requests ringing, 0 requests talk |
| hold_en | input | 1 | 1 freezes the ringing command |
| shdn_req_n | input | 1 | Active-low request for all-off |
| overtemp | input | 1 | Over-temperature flag |
| zc_strobe | input | 1 | Ringing current zero crossing |
| vbat_sample | input | VBAT_W | Signed battery voltage in volts |
| brk_en | output | BRK_N | Break switch enables |
| ring_ret_en | output | 1 | Ringing-return switch enable |
| ring_src_en | output | 1 | Ringing switch enable |
| state_code | output | 2 | Switch state code per R11 |
| shdn_stat_n | output | 1 | Low while over-temperature |

## Verification
Each output, including the battery fault condition and the command hold, is registered once, so the result of inputs sampled at one rising edge is due on the outputs right after that edge. The bench drives inputs on the falling edge, advances its behavioural model at the rising edge from those same input values, and compares all outputs with the model at the following falling edge. The zero-crossing hold is also checked directly: if the ringing switch was on and no strobe was sampled, it must still be on one edge later.

// File: rtl/lcsw_pkg.sv
package lcsw_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_TALK = 2'd1,
    ST_RING = 2'd2,
    ST_WAIT = 2'd3
  } sw_state_e;

  typedef struct packed {
    logic brk;
    logic ret;
    logic src;
  } sw_set_t;

endpackage

// File: rtl/lcsw_cmd_hold.sv
module lcsw_cmd_hold (
  input  logic clk,
  input  logic rst,
  input  logic cmd_in,
  input  logic hold_en,
  output logic cmd_eff
);

  logic held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
    end else if (!hold_en) begin
      held_q <= cmd_in;
    end
  end

  assign cmd_eff = hold_en ? held_q : cmd_in;

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    hold_en |=> (held_q == $past(held_q)));

endmodule

// File: rtl/lcsw_batt_mon.sv
module lcsw_batt_mon #(
  parameter int VBAT_W    = 8,
  parameter int TRIP_V    = -10,
  parameter int RESTORE_V = -15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [VBAT_W-1:0] sample,
  output logic                     fault_next
);

  logic fault_q;
  logic above_trip;
  logic below_restore;

  assign above_trip    = int'(sample) > TRIP_V;
  assign below_restore = int'(sample) < RESTORE_V;

  always_comb begin
    if (above_trip)         fault_next = 1'b1;
    else if (below_restore) fault_next = 1'b0;
    else                    fault_next = fault_q;
  end

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b1;
    else     fault_q <= fault_next;
  end

  a_r8_band_keeps: assert property (@(posedge clk) disable iff (rst)
    (!above_trip && !below_restore) |-> (fault_next == fault_q));

endmodule

// File: rtl/lcsw_switch_seq.sv
module lcsw_switch_seq
  import lcsw_pkg::*;
#(
  parameter int BRK_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_off,
  input  logic             ring_req,
  input  logic             zc,
  output logic [BRK_N-1:0] brk_en,
  output logic             ret_en,
  output logic             src_en,
  output logic [1:0]       code
);

  sw_set_t   cur_q;
  sw_set_t   nxt;
  sw_state_e code_q;
  sw_state_e code_nxt;

  always_comb begin
    nxt.brk = !force_off && !ring_req;
    nxt.ret = !force_off && ring_req;
    nxt.src = nxt.ret || (cur_q.src && !zc);
    if (nxt.ret)      code_nxt = ST_RING;
    else if (nxt.src) code_nxt = ST_WAIT;
    else if (nxt.brk) code_nxt = ST_TALK;
    else              code_nxt = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      code_q <= ST_OFF;
    end else begin
      cur_q  <= nxt;
      code_q <= code_nxt;
    end
  end

  assign brk_en = {BRK_N{cur_q.brk}};
  assign ret_en = cur_q.ret;
  assign src_en = cur_q.src;
  assign code   = code_q;

  a_r5_zc_hold: assert property (@(posedge clk) disable iff (rst)
    (cur_q.src && !zc) |=> cur_q.src);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(cur_q.brk && cur_q.ret));

  a_r11_wait_code: assert property (@(posedge clk) disable iff (rst)
    (cur_q.src && !cur_q.ret) |-> (code_q == ST_WAIT));

endmodule

// File: rtl/linecard_switch_ctrl.sv
module linecard_switch_ctrl #(
  parameter int VBAT_W    = 8,
  parameter int BRK_N     = 2,
  parameter int TRIP_V    = -10,
  parameter int RESTORE_V = -15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ring_cmd,
  input  logic                     hold_en,
  input  logic                     shdn_req_n,
  input  logic                     overtemp,
  input  logic                     zc_strobe,
  input  logic signed [VBAT_W-1:0] vbat_sample,
  output logic [BRK_N-1:0]         brk_en,
  output logic                     ring_ret_en,
  output logic                     ring_src_en,
  output logic [1:0]               state_code,
  output logic                     shdn_stat_n
);

  logic cmd_eff;
  logic batt_fault;
  logic force_off;

  lcsw_cmd_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .cmd_in  (ring_cmd),
    .hold_en (hold_en),
    .cmd_eff (cmd_eff)
  );

  lcsw_batt_mon #(
    .VBAT_W    (VBAT_W),
    .TRIP_V    (TRIP_V),
    .RESTORE_V (RESTORE_V)
  ) u_batt (
    .clk        (clk),
    .rst        (rst),
    .sample     (vbat_sample),
    .fault_next (batt_fault)
  );

  // Over-temperature, battery fault and shutdown request all bypass the hold.
  assign force_off = overtemp || batt_fault || !shdn_req_n;

  lcsw_switch_seq #(
    .BRK_N (BRK_N)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .force_off (force_off),
    .ring_req  (cmd_eff),
    .zc        (zc_strobe),
    .brk_en    (brk_en),
    .ret_en    (ring_ret_en),
    .src_en    (ring_src_en),
    .code      (state_code)
  );

  always_ff @(posedge clk) begin
    if (rst) shdn_stat_n <= 1'b1;
    else     shdn_stat_n <= !overtemp;
  end

  a_r9_overtemp_off: assert property (@(posedge clk) disable iff (rst)
    overtemp |=> (brk_en == '0 && !ring_ret_en && !shdn_stat_n));

  a_r4_shdn_off: assert property (@(posedge clk) disable iff (rst)
    !shdn_req_n |=> (brk_en == '0 && !ring_ret_en));

  a_r8_trip_off: assert property (@(posedge clk) disable iff (rst)
    (int'(vbat_sample) > TRIP_V) |=> (brk_en == '0 && !ring_ret_en));

endmodule

// File: tb/linecard_switch_ctrl_test.sv
`timescale 1ns/1ps
module linecard_switch_ctrl_test;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ring_cmd = 1'b0;
  logic              hold_en = 1'b0;
  logic              shdn_req_n = 1'b1;
  logic              overtemp = 1'b0;
  logic              zc_strobe = 1'b0;
  logic signed [7:0] vbat_sample = 8'sd0;
  logic [1:0]        brk_en;
  logic              ring_ret_en;
  logic              ring_src_en;
  logic [1:0]        state_code;
  logic              shdn_stat_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit started = 0;
  string tag = "R10";

  always #5 clk = ~clk;

  linecard_switch_ctrl uut (
    .clk(clk), .rst(rst), .ring_cmd(ring_cmd), .hold_en(hold_en),
    .shdn_req_n(shdn_req_n), .overtemp(overtemp), .zc_strobe(zc_strobe),
    .vbat_sample(vbat_sample), .brk_en(brk_en), .ring_ret_en(ring_ret_en),
    .ring_src_en(ring_src_en), .state_code(state_code), .shdn_stat_n(shdn_stat_n)
  );

  // Behavioural reference model, advanced at each rising edge.
  bit m_fault, m_held, m_brk, m_ret, m_src, m_stat;
  int m_code;
  bit pre_src, pre_zc;

  always @(posedge clk) begin
    bit eff, off;
    int v;
    pre_src = ring_src_en;
    pre_zc  = zc_strobe;
    if (rst) begin
      m_fault = 1; m_held = 0; m_brk = 0; m_ret = 0; m_src = 0;
      m_stat = 1; m_code = 0;
    end else begin
      v = int'(vbat_sample);
      if (v > -10) m_fault = 1;
      else if (v < -15) m_fault = 0;
      eff = hold_en ? m_held : ring_cmd;
      if (!hold_en) m_held = ring_cmd;
      off = overtemp || m_fault || !shdn_req_n;
      m_brk = !off && !eff;
      m_ret = !off && eff;
      m_src = m_ret || (m_src && !zc_strobe);
      m_stat = !overtemp;
      m_code = m_ret ? 2 : (m_src ? 3 : (m_brk ? 1 : 0));
    end
    started = 1;
  end

  task automatic check(string t, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check({tag, " brk_en"}, brk_en, m_brk ? 3 : 0);
      check({tag, " ring_ret_en"}, ring_ret_en, m_ret);
      check({tag, " ring_src_en"}, ring_src_en, m_src);
      check({tag, " state_code R11"}, state_code, m_code);
      check({tag, " shdn_stat_n R9"}, shdn_stat_n, m_stat);
      if (!rst && pre_src && !pre_zc)
        check("R5 zero-cross hold", ring_src_en, 1);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Directed port check of the settled switch set.
  task automatic expect_set(string t, int code, int brk, int ret, int src);
    check({t, " code"}, state_code, code);
    check({t, " brk"}, brk_en, brk);
    check({t, " ret"}, ring_ret_en, ret);
    check({t, " src"}, ring_src_en, src);
  endtask

  task automatic pulse_zc();
    zc_strobe = 1; step(1); zc_strobe = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lfsr;
    step(3);
    tag = "R10";
    expect_set("R10 reset all-off", 0, 0, 0, 0);
    check("R10 reset status", shdn_stat_n, 1);
    rst = 0;
    step(2);
    expect_set("R10 no battery yet", 0, 0, 0, 0);
    tag = "R8";
    vbat_sample = -12; step(2);
    expect_set("R8 band keeps fault", 0, 0, 0, 0);
    vbat_sample = -15; step(2);
    expect_set("R8 -15 keeps fault", 0, 0, 0, 0);
    vbat_sample = -16; step(1);
    tag = "R2";
    expect_set("R12 R2 talk after one edge", 1, 3, 0, 0);
    ring_cmd = 1; step(1);
    expect_set("R2 ringing", 2, 0, 1, 1);
    step(3);
    tag = "R6";
    ring_cmd = 0; step(1);
    expect_set("R6 make-before-break wait", 3, 3, 0, 1);
    step(4);
    expect_set("R5 still waiting", 3, 3, 0, 1);
    pulse_zc();
    expect_set("R6 talk after zc", 1, 3, 0, 0);
    tag = "R7";
    ring_cmd = 1; step(2);
    shdn_req_n = 0; step(1);
    expect_set("R7 break-before-make wait", 3, 0, 0, 1);
    step(3);
    pulse_zc();
    expect_set("R7 all-off after zc", 0, 0, 0, 0);
    ring_cmd = 0; shdn_req_n = 1; step(1);
    expect_set("R7 release to talk", 1, 3, 0, 0);
    tag = "R3";
    ring_cmd = 1; step(1);
    hold_en = 1; ring_cmd = 0; step(3);
    expect_set("R3 hold keeps ringing", 2, 0, 1, 1);
    tag = "R4";
    shdn_req_n = 0; step(2);
    pulse_zc();
    expect_set("R4 shutdown bypasses hold", 0, 0, 0, 0);
    shdn_req_n = 1; step(1);
    expect_set("R3 held value returns", 2, 0, 1, 1);
    hold_en = 0; step(1);
    expect_set("R3 transparent again", 3, 3, 0, 1);
    pulse_zc();
    tag = "R9";
    ring_cmd = 1; step(1);
    overtemp = 1; step(1);
    expect_set("R9 overtemp wait", 3, 0, 0, 1);
    check("R9 status low", shdn_stat_n, 0);
    pulse_zc(); step(1);
    expect_set("R9 overtemp all-off", 0, 0, 0, 0);
    overtemp = 0; ring_cmd = 0; step(1);
    check("R9 status high", shdn_stat_n, 1);
    tag = "R8";
    vbat_sample = -10; step(2);
    expect_set("R8 -10 no trip", 1, 3, 0, 0);
    vbat_sample = -9; step(1);
    expect_set("R8 trip above -10", 0, 0, 0, 0);
    vbat_sample = -12; step(2);
    expect_set("R8 stays tripped", 0, 0, 0, 0);
    vbat_sample = -48; step(1);
    expect_set("R8 recovery", 1, 3, 0, 0);
    tag = "R1";
    lfsr = 32'h1ACE5;
    for (int i = 0; i < 2000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      ring_cmd   = lfsr[3];
      hold_en    = (lfsr[7:5] == 0);
      zc_strobe  = (lfsr[10:8] == 0);
      shdn_req_n = (lfsr[14:12] != 0);
      overtemp   = (lfsr[19:15] == 0);
      case (lfsr[23:21])
        0: vbat_sample = 0;
        1: vbat_sample = -9;
        2: vbat_sample = -12;
        3: vbat_sample = -15;
        4: vbat_sample = 127;
        default: vbat_sample = -48;
      endcase
      step(1);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule